// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block brings a clock buffer from power off to normal operation through four states. It waits for the supply to be reported good. It then runs a settling delay of a programmable number of timing-clock cycles. Next it waits for an input reference clock, for the power-down request to be released and for the PLL to report lock. Only after all of these are met does it enable the clock outputs. Supply sensing, clock detection and the PLL sit outside the block and arrive as level flags. The power-down request must already be synchronized to `clk`.

The block also keeps a sticky lock-status flag. The flag is set when the PLL reports lock, and it is cleared only when power-down is requested or the supply drops. A second sticky flag reports a start-up timeout. It is raised when the block waits too long in the lock-wait state with power-down released. It stays set until the supply is lost.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst_n` is low, `state` is 0 and `out_en`, `lock_flag` and `late_flag` are 0.
- R2: `state` is a 2-bit code: 0 = off, 1 = settle, 2 = wait for clock/lock, 3 = run. From state 0 the block moves to state 1 on the first edge where `supply_ok` is high, and to no other state.
- R3: State 1 lasts exactly `DELAY_CYC` clock cycles and is then followed by state 2. The delay restarts from zero on every entry into state 1.
- R4: From state 2 the block moves to state 3 only on an edge where `clk_seen` is high, `pd_req` is low and `pll_raw_lock` is high. Otherwise it stays in state 2, including when no input clock is detected.
- R5: `out_en` is high in state 3 and low in every other state.
- R6: An edge with `supply_ok` low puts the block in state 0 on the next cycle, whatever the current state. This has priority over every other transition.
- R7: `pd_req` high in state 3, with the supply good, returns the block to state 2 on the next cycle.
- R8: `lock_flag` is set by an edge with `pll_raw_lock` high while `supply_ok` is high and `pd_req` is low. It stays set when `pll_raw_lock` falls. It is cleared on any edge with `pd_req` high or `supply_ok` low, and clearing wins over setting.
- R9: `late_flag` rises after `TIMEOUT_CYC` consecutive edges in state 2 with `pd_req` low. The count restarts when state 2 is left or `pd_req` is high. The flag stays set until the block is in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above the low-voltage threshold |
| clk_seen | input | 1 | Valid input reference clock detected |
| pd_req | input | 1 | Synchronized power-down request, active high |
| pll_raw_lock | input | 1 | Raw PLL lock indication |
| state | output | 2 | Current sequencer state (0 to 3) |
| out_en | output | 1 | Clock output enable |
| lock_flag | output | 1 | Sticky lock status |
| late_flag | output | 1 | Sticky start-up timeout flag |

## Verification
Several properties are checked on every cycle:
- a supply drop always lands in state 0;
- power-down in the run state always falls back to state 2;
- leaving state 0 can only lead to state 1;
- run state is only entered from state 2 with all three start conditions present;
- the lock flag is always clear after a clearing edge;
- enabled outputs imply a set lock flag.

Some behaviours can only be shown by the bench's scenarios. These are the exact length of the settle delay and its restart after an aborted settle, the stickiness of the lock flag across a falling raw lock, and the exact cycle on which the timeout flag rises. Long random runs then compare every output against a cycle model.

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int DELAY_CYC   = 20,
  parameter int TIMEOUT_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       clk_seen,
  input  logic       pd_req,
  input  logic       pll_raw_lock,
  output logic [1:0] state,
  output logic       out_en,
  output logic       lock_flag,
  output logic       late_flag
);
  localparam int DW = $clog2(DELAY_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [DW-1:0] DLAST = DW'(DELAY_CYC - 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_CYC - 1);

  localparam logic [1:0] S_OFF    = 2'd0;
  localparam logic [1:0] S_SETTLE = 2'd1;
  localparam logic [1:0] S_WAIT   = 2'd2;
  localparam logic [1:0] S_RUN    = 2'd3;

  logic [1:0]    st;
  logic [DW-1:0] dcnt;
  logic [TW-1:0] wcnt;
  logic          lock_q, late_q;
  logic          go, waiting;

  assign go      = clk_seen && !pd_req && pll_raw_lock;
  assign waiting = (st == S_WAIT) && !pd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st <= S_OFF;
    else if (!supply_ok)
      st <= S_OFF;
    else begin
      case (st)
        S_OFF:    st <= S_SETTLE;
        S_SETTLE: if (dcnt == DLAST) st <= S_WAIT;
        S_WAIT:   if (go) st <= S_RUN;
        default:  if (pd_req) st <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dcnt <= '0;
    else if (st == S_SETTLE) dcnt <= dcnt + 1'b1;
    else                    dcnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wcnt <= '0;
    else if (!waiting)       wcnt <= '0;
    else if (wcnt != TLAST)  wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          late_q <= 1'b0;
    else if (st == S_OFF)                late_q <= 1'b0;
    else if (waiting && wcnt == TLAST)   late_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     lock_q <= 1'b0;
    else if (pd_req || !supply_ok)  lock_q <= 1'b0;
    else if (pll_raw_lock)          lock_q <= 1'b1;
  end

  assign state     = st;
  assign out_en    = (st == S_RUN);
  assign lock_flag = lock_q;
  assign late_flag = late_q;

  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> st == S_OFF); // R6
  AST_OFF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_OFF |=> (st == S_OFF || st == S_SETTLE)); // R2
  AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && $past(st) == S_SETTLE) |-> $past(dcnt) == DLAST); // R3
  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> ($past(st) == S_WAIT && $past(clk_seen) && !$past(pd_req) && $past(pll_raw_lock))); // R4
  AST_PD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && pd_req && supply_ok) |=> st == S_WAIT); // R7
  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req || !supply_ok) |=> !lock_q); // R8
  AST_RUN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> lock_q); // R5
  AST_LATE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_q) |-> $past(st) == S_WAIT); // R9
endmodule

// File: tb/sim_pwrup_seq.sv
module sim_pwrup_seq;
  localparam int DLY = 6;
  localparam int TMO = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 1'b0, clk_seen = 1'b0, pd_req = 1'b0, pll_raw_lock = 1'b0;
  logic [1:0] state;
  logic out_en, lock_flag, late_flag;

  pwrup_seq #(.DELAY_CYC(DLY), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .clk_seen(clk_seen),
    .pd_req(pd_req), .pll_raw_lock(pll_raw_lock), .state(state),
    .out_en(out_en), .lock_flag(lock_flag), .late_flag(late_flag));

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int m_st = 0, m_dc = 0, m_wc = 0, m_lk = 0, m_lt = 0;

  function automatic int f_state(int s, int dc, logic sup, logic cs, logic pd, logic pl);
    if (!sup) return 0;
    case (s)
      0: return 1;
      1: return (dc == DLY - 1) ? 2 : 1;
      2: return (cs && !pd && pl) ? 3 : 2;
      default: return pd ? 2 : 3;
    endcase
  endfunction

  function automatic int f_lock(int lk, logic sup, logic pd, logic pl);
    if (pd || !sup) return 0;
    return pl ? 1 : lk;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int ns, nd, nw, nl, nt;
    logic wt;
    wt = (m_st == 2) && !pd_req;
    ns = f_state(m_st, m_dc, supply_ok, clk_seen, pd_req, pll_raw_lock);
    nd = (m_st == 1) ? m_dc + 1 : 0;
    nw = !wt ? 0 : (m_wc != TMO - 1 ? m_wc + 1 : m_wc);
    nt = (m_st == 0) ? 0 : ((wt && m_wc == TMO - 1) ? 1 : m_lt);
    nl = f_lock(m_lk, supply_ok, pd_req, pll_raw_lock);
    m_st = ns; m_dc = nd; m_wc = nw; m_lt = nt; m_lk = nl;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " state R2"}, int'(state), m_st);
    check({tag, " out_en R5"}, int'(out_en), (m_st == 3) ? 1 : 0);
    check({tag, " lock R8"}, int'(lock_flag), m_lk);
    check({tag, " late R9"}, int'(late_flag), m_lt);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int cnt;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check("reset state R1", int'(state), 0);
    check("reset out_en R1", int'(out_en), 0);
    check("reset lock R1", int'(lock_flag), 0);
    check("reset late R1", int'(late_flag), 0);
    rst_n = 1'b1;
    repeat (3) tick("off");
    check("hold off R2", int'(state), 0);
    supply_ok = 1'b1;
    tick("power");
    check("enter settle R2", int'(state), 1);
    cnt = 1;
    while (state == 2'd1 && cnt < 100) begin tick("settle"); if (state == 2'd1) cnt++; end
    check("settle length R3", cnt, DLY);
    check("after settle R3", int'(state), 2);
    pll_raw_lock = 1'b1; clk_seen = 1'b0;
    repeat (4) tick("noclk");
    check("no clock stays R4", int'(state), 2);
    check("no clock oe R5", int'(out_en), 0);
    clk_seen = 1'b1; pd_req = 1'b1;
    repeat (3) tick("pdhold");
    check("pd holds wait R4", int'(state), 2);
    pd_req = 1'b0;
    tick("go");
    check("run entry R4", int'(state), 3);
    check("run oe R5", int'(out_en), 1);
    check("lock set R8", int'(lock_flag), 1);
    pll_raw_lock = 1'b0;
    tick("lockdrop");
    check("lock sticky R8", int'(lock_flag), 1);
    pd_req = 1'b1;
    tick("pdrun");
    check("pd exit R7", int'(state), 2);
    check("pd clears lock R8", int'(lock_flag), 0);
    pd_req = 1'b0;
    for (int i = 0; i < TMO - 1; i++) tick("wait");
    check("late not yet R9", int'(late_flag), 0);
    tick("wait");
    check("late raised R9", int'(late_flag), 1);
    tick("wait");
    check("late sticky R9", int'(late_flag), 1);
    supply_ok = 1'b0;
    tick("drop");
    check("drop to off R6", int'(state), 0);
    tick("off2");
    check("late cleared R9", int'(late_flag), 0);
    supply_ok = 1'b1;
    repeat (3) tick("resettle");
    supply_ok = 1'b0;
    tick("abort");
    check("abort settle R6", int'(state), 0);
    supply_ok = 1'b1;
    tick("repower");
    cnt = 1;
    while (state == 2'd1 && cnt < 100) begin tick("settle2"); if (state == 2'd1) cnt++; end
    check("settle restart R3", cnt, DLY);
    for (int i = 0; i < 6000; i++) begin
      supply_ok    = ($urandom_range(99) < 97);
      clk_seen     = ($urandom_range(99) < 80);
      pll_raw_lock = ($urandom_range(99) < 60);
      if ($urandom_range(99) < 8) pd_req = ~pd_req;
      tick("rand");
    end
    finish_run();
  end
endmodule